// File: doc/BRIEF.md
# Palette DAC Control and Status Register File

This block is the host-side set of control registers for a family of true-colour palette DACs. A host reaches it through a 4-bit register-select code, a write strobe, a read strobe and an 8-bit data bus. It holds a palette address register, four command registers (0 to 3) and, on the newest family member, a fifth command register (4). It also holds a read-only identification byte whose value depends on a static variant-select input.

The extended registers (command register 3, command register 4, the identification byte and the signature read-back slots) all share one select code. Which of them an access reaches depends on the current value of the palette address register. That path only opens when bit 7 of command register 0 is set and the variant is one of the newer members; when it is closed, the shared code reads back the identification byte.

The block decodes three outputs for the rest of the display pipeline:
- the palette data width (6-bit or 8-bit),
- the hardware cursor size (32x32 or 64x64),
- the cursor Y offset.

A command register 3 write that leaves the cursor at 64x64 also loads the top two bits of the palette address register.

Top module: `ramdac_ctl`

## Requirements
- R1: A synchronous active-high reset clears the address register and all command registers to 0. After reset, `pal_wide_o`=0, `cursor_big_o`=0 and `cursor_yoff_o`=32.
- R2: Select code 4'b0110 reads and writes command register 0. Bit 1 of that register drives `pal_wide_o`, where 1 means 8-bit palette data, one cycle after the write.
- R3: Select codes 4'b1000 and 4'b1001 read and write command registers 1 and 2. Each returns its last written value.
- R4: Select code 4'b0000 writes bits 7:0 of the 10-bit address register and clears bits 9:8. A read of that code returns bits 7:0, and `addr_o` shows all 10 bits.
- R5: When command register 0 bit 7 is clear, or the variant is 0 or 1, the extended path is closed. A read of select code 4'b1010 then returns the identification byte, and a write to it changes nothing.
- R6: The identification byte is 0x80, 0x40, 0xA0, 0xD0 or 0x20 for variant codes 0, 1, 2, 3 and 4. It is loaded during reset and holds afterwards.
- R7: With the extended path open, address register value 0x000 reads the identification byte, and value 0x001 reads and writes command register 3. Any address that matches no extended slot reads 0x00.
- R8: Address value 0x002 reads and writes command register 4 only on variant 4. On other variants that address reads 0x00 and ignores writes.
- R9: On variant 4, address values 0x020 to 0x022 read 0xFF and ignore writes. On other variants they read 0x00.
- R10: On variants 2 to 4, command register 3 bit 2 set selects a 64x64 cursor with `cursor_yoff_o`=0. Bit 2 clear selects 32x32 with `cursor_yoff_o`=32.
- R11: A command register 3 write with data bit 2 set copies data bits 1:0 into address bits 9:8 and keeps address bits 7:0. With data bit 2 clear, the address register is unchanged.
- R12: Variants 0 and 1 always present a 32x32 cursor with `cursor_yoff_o`=32.
- R13: Select codes with no register read 0x00 and ignore writes. `rdata_o` is 0 while `rd_i` is low, and a read returns the value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_i | input | 3 | Static family member code, 0 to 4 |
| sel_i | input | 4 | Register-select code |
| wr_i | input | 1 | Write strobe, sampled at the clock edge |
| rd_i | input | 1 | Read strobe, enables `rdata_o` |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| addr_o | output | 10 | Palette address register |
| pal_wide_o | output | 1 | 1 = 8-bit palette data, 0 = 6-bit |
| cursor_big_o | output | 1 | 1 = 64x64 cursor, 0 = 32x32 |
| cursor_yoff_o | output | 7 | Cursor Y offset (32 or 0) |

## Verification
The bench leaves a command register 3 write in 64x64 mode with a non-zero value in the upper address bits, so the address register no longer selects command register 3. A design that compared only the low address byte would keep reaching the register; one that rewrote the whole address, or skipped the side effect, would show a wrong `addr_o`.

The bench writes through the shared select code while the extended path is closed. This applies both to a disabled command register 0 and to older variants, and a design that leaked such a write would change the cursor outputs or the value of command register 3 read back later.

The register 4 and signature addresses are probed on variant 3 and variant 4. This catches a design that gates them only on "newer" rather than "newest". The bench also resets through all five variants, which catches a swapped identification byte.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    localparam int DW = 8;
    localparam int AW = 10;
    localparam int SW = 4;
    localparam int VW = 3;
    localparam int YOFF_W = 7;
    localparam int CUR_SMALL = 32;

    localparam logic [SW-1:0] SEL_ADDR = 4'b0000;
    localparam logic [SW-1:0] SEL_CMD0 = 4'b0110;
    localparam logic [SW-1:0] SEL_CMD1 = 4'b1000;
    localparam logic [SW-1:0] SEL_CMD2 = 4'b1001;
    localparam logic [SW-1:0] SEL_EXT  = 4'b1010;

    localparam int EXT_STAT   = 'h000;
    localparam int EXT_CMD3   = 'h001;
    localparam int EXT_CMD4   = 'h002;
    localparam int EXT_SIG_LO = 'h020;
    localparam int EXT_SIG_HI = 'h022;

    localparam int EN_BIT    = 7;
    localparam int WIDE_BIT  = 1;
    localparam int BIG_BIT   = 2;

    typedef enum logic [VW-1:0] {
        VAR_OLD_A = 3'd0,
        VAR_OLD_B = 3'd1,
        VAR_MID_A = 3'd2,
        VAR_MID_B = 3'd3,
        VAR_TOP   = 3'd4
    } variant_e;

    typedef struct packed {
        logic addr;
        logic cmd0;
        logic cmd1;
        logic cmd2;
        logic cmd3;
        logic cmd4;
    } wr_en_t;

    typedef enum logic [3:0] {
        RD_ZERO,
        RD_ADDR,
        RD_CMD0,
        RD_CMD1,
        RD_CMD2,
        RD_CMD3,
        RD_CMD4,
        RD_STAT,
        RD_ONES
    } rd_src_e;

    function automatic logic [DW-1:0] variant_id(input logic [VW-1:0] v);
        case (v)
            VAR_OLD_A: return 8'h80;
            VAR_OLD_B: return 8'h40;
            VAR_MID_A: return 8'hA0;
            VAR_MID_B: return 8'hD0;
            VAR_TOP:   return 8'h20;
            default:   return 8'h00;
        endcase
    endfunction

    function automatic logic has_ext(input logic [VW-1:0] v);
        return v >= VAR_MID_A;
    endfunction

    function automatic logic has_cmd4(input logic [VW-1:0] v);
        return v == VAR_TOP;
    endfunction

endpackage

// File: rtl/rdc_decode.sv
module rdc_decode
    import rdc_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int SEL_W  = SW
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              wr_i,
    input  logic              ext_en_i,
    input  logic [VW-1:0]     variant_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_en_t            we_o,
    output rd_src_e           src_o
);

    logic ext_open;
    logic is_sig;

    assign ext_open = ext_en_i && has_ext(variant_i);
    assign is_sig   = (addr_i >= ADDR_W'(EXT_SIG_LO)) && (addr_i <= ADDR_W'(EXT_SIG_HI));

    always_comb begin
        we_o  = '0;
        src_o = RD_ZERO;
        case (sel_i)
            SEL_ADDR: begin
                we_o.addr = wr_i;
                src_o     = RD_ADDR;
            end
            SEL_CMD0: begin
                we_o.cmd0 = wr_i;
                src_o     = RD_CMD0;
            end
            SEL_CMD1: begin
                we_o.cmd1 = wr_i;
                src_o     = RD_CMD1;
            end
            SEL_CMD2: begin
                we_o.cmd2 = wr_i;
                src_o     = RD_CMD2;
            end
            SEL_EXT: begin
                if (!ext_open) begin
                    src_o = RD_STAT;
                end else if (addr_i == ADDR_W'(EXT_STAT)) begin
                    src_o = RD_STAT;
                end else if (addr_i == ADDR_W'(EXT_CMD3)) begin
                    we_o.cmd3 = wr_i;
                    src_o     = RD_CMD3;
                end else if (addr_i == ADDR_W'(EXT_CMD4) && has_cmd4(variant_i)) begin
                    we_o.cmd4 = wr_i;
                    src_o     = RD_CMD4;
                end else if (is_sig && has_cmd4(variant_i)) begin
                    src_o = RD_ONES;
                end
            end
            default: begin
                src_o = RD_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/rdc_regs.sv
module rdc_regs
    import rdc_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VW-1:0]     variant_i,
    input  wr_en_t            we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] cmd0_q,
    output logic [DATA_W-1:0] cmd1_q,
    output logic [DATA_W-1:0] cmd2_q,
    output logic [DATA_W-1:0] cmd3_q,
    output logic [DATA_W-1:0] cmd4_q,
    output logic [DATA_W-1:0] status_q
);

    localparam int HI_W = ADDR_W - DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            cmd0_q   <= '0;
            cmd1_q   <= '0;
            cmd2_q   <= '0;
            cmd3_q   <= '0;
            cmd4_q   <= '0;
            status_q <= variant_id(variant_i);
        end else begin
            if (we_i.addr) addr_q <= {{HI_W{1'b0}}, wdata_i};
            if (we_i.cmd0) cmd0_q <= wdata_i;
            if (we_i.cmd1) cmd1_q <= wdata_i;
            if (we_i.cmd2) cmd2_q <= wdata_i;
            if (we_i.cmd4) cmd4_q <= wdata_i;
            if (we_i.cmd3) begin
                cmd3_q <= wdata_i;
                if (wdata_i[BIG_BIT])
                    addr_q[ADDR_W-1:DATA_W] <= wdata_i[HI_W-1:0];
            end
        end
    end

    // R11: a large-cursor register 3 write loads only the address high bits
    p_cmd3_addr_hi_r11: assert property (@(posedge clk) disable iff (rst)
        (we_i.cmd3 && wdata_i[BIG_BIT]) |=>
            (addr_q[DATA_W-1:0] == $past(addr_q[DATA_W-1:0])) &&
            (addr_q[ADDR_W-1:DATA_W] == $past(wdata_i[HI_W-1:0])));

    // R4: a direct address write clears the high bits
    p_addr_load_r4: assert property (@(posedge clk) disable iff (rst)
        we_i.addr |=> (addr_q[ADDR_W-1:DATA_W] == '0) &&
                      (addr_q[DATA_W-1:0] == $past(wdata_i)));

    // R6: identification byte matches the variant and never changes
    p_status_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_q == variant_id(variant_i)) && $stable(status_q));

endmodule

// File: rtl/rdc_cursor.sv
module rdc_cursor
    import rdc_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic [VW-1:0]     variant_i,
    input  logic [DATA_W-1:0] cmd3_i,
    output logic              big_o,
    output logic [YOFF_W-1:0] yoff_o
);

    assign big_o  = has_ext(variant_i) && cmd3_i[BIG_BIT];
    assign yoff_o = big_o ? '0 : YOFF_W'(CUR_SMALL);

endmodule

// File: rtl/ramdac_ctl.sv
module ramdac_ctl
    import rdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        variant_i,
    input  logic [3:0]        sel_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic [9:0]        addr_o,
    output logic              pal_wide_o,
    output logic              cursor_big_o,
    output logic [6:0]        cursor_yoff_o
);

    wr_en_t  we;
    rd_src_e src;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] cmd0_q, cmd1_q, cmd2_q, cmd3_q, cmd4_q, status_q;
    logic [DW-1:0] rd_mux;

    rdc_decode #(.ADDR_W(AW), .SEL_W(SW)) u_decode (
        .sel_i     (sel_i),
        .wr_i      (wr_i),
        .ext_en_i  (cmd0_q[EN_BIT]),
        .variant_i (variant_i),
        .addr_i    (addr_q),
        .we_o      (we),
        .src_o     (src)
    );

    rdc_regs #(.DATA_W(DW), .ADDR_W(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .variant_i (variant_i),
        .we_i      (we),
        .wdata_i   (wdata_i),
        .addr_q    (addr_q),
        .cmd0_q    (cmd0_q),
        .cmd1_q    (cmd1_q),
        .cmd2_q    (cmd2_q),
        .cmd3_q    (cmd3_q),
        .cmd4_q    (cmd4_q),
        .status_q  (status_q)
    );

    rdc_cursor #(.DATA_W(DW)) u_cursor (
        .variant_i (variant_i),
        .cmd3_i    (cmd3_q),
        .big_o     (cursor_big_o),
        .yoff_o    (cursor_yoff_o)
    );

    always_comb begin
        case (src)
            RD_ADDR: rd_mux = addr_q[DW-1:0];
            RD_CMD0: rd_mux = cmd0_q;
            RD_CMD1: rd_mux = cmd1_q;
            RD_CMD2: rd_mux = cmd2_q;
            RD_CMD3: rd_mux = cmd3_q;
            RD_CMD4: rd_mux = cmd4_q;
            RD_STAT: rd_mux = status_q;
            RD_ONES: rd_mux = '1;
            default: rd_mux = '0;
        endcase
    end

    assign rdata_o    = rd_i ? rd_mux : '0;
    assign addr_o     = addr_q;
    assign pal_wide_o = cmd0_q[WIDE_BIT];

    // R13: at most one register takes a write per cycle
    p_we_onehot_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

    // R5: a write through a closed extended path leaves the extended state alone
    p_ext_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i == SEL_EXT && !(cmd0_q[EN_BIT] && has_ext(variant_i))) |=>
            $stable(cmd3_q) && $stable(cmd4_q) && $stable(addr_q));

    // R2: palette width follows the written bit 1 one cycle later
    p_pal_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i == SEL_CMD0) |=> (pal_wide_o == $past(wdata_i[WIDE_BIT])));

    // R12: older variants keep the small cursor
    p_old_cursor_r12: assert property (@(posedge clk) disable iff (rst)
        !has_ext(variant_i) |-> (!cursor_big_o && cursor_yoff_o == 7'd32));

    // R10: large cursor carries no Y offset
    p_big_yoff_r10: assert property (@(posedge clk) disable iff (rst)
        cursor_big_o |-> (cursor_yoff_o == 7'd0));

endmodule

// File: tb/ramdac_ctl_bench.sv
module ramdac_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] variant_i = 3'd2;
    logic [3:0] sel_i = 4'h0;
    logic       wr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic [9:0] addr_o;
    logic       pal_wide_o;
    logic       cursor_big_o;
    logic [6:0] cursor_yoff_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    ramdac_ctl u_ramdac_ctl (
        .clk           (clk),
        .rst           (rst),
        .variant_i     (variant_i),
        .sel_i         (sel_i),
        .wr_i          (wr_i),
        .rd_i          (rd_i),
        .wdata_i       (wdata_i),
        .rdata_o       (rdata_o),
        .addr_o        (addr_o),
        .pal_wide_o    (pal_wide_o),
        .cursor_big_o  (cursor_big_o),
        .cursor_yoff_o (cursor_yoff_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] v);
        @(negedge clk);
        variant_i = v;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        sel_i = s; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] s, output logic [7:0] d);
        @(negedge clk);
        sel_i = s; rd_i = 1'b1;
        #1;
        d = rdata_o;
        rd_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset(3'd2);
        check("R1 addr", 16'(addr_o), 16'h000);
        check("R1 pal_wide", 16'(pal_wide_o), 16'h0);
        check("R1 cursor_big", 16'(cursor_big_o), 16'h0);
        check("R1 yoff", 16'(cursor_yoff_o), 16'd32);
        do_rd(4'b0110, d);
        check("R1 cmd0", 16'(d), 16'h00);
        check("R13 idle rdata", 16'(rdata_o), 16'h00);
    endtask

    task automatic t_cmd0();
        logic [7:0] d;
        do_reset(3'd2);
        do_wr(4'b0110, 8'h02);
        check("R2 wide set", 16'(pal_wide_o), 16'h1);
        do_rd(4'b0110, d);
        check("R2 readback", 16'(d), 16'h02);
        do_wr(4'b0110, 8'hFD);
        check("R2 wide clear", 16'(pal_wide_o), 16'h0);
        do_rd(4'b0110, d);
        check("R2 readback2", 16'(d), 16'hFD);
    endtask

    task automatic t_cmd12();
        logic [7:0] d;
        do_reset(3'd2);
        do_wr(4'b1000, 8'h5A);
        do_wr(4'b1001, 8'hC3);
        do_rd(4'b1000, d);
        check("R3 cmd1", 16'(d), 16'h5A);
        do_rd(4'b1001, d);
        check("R3 cmd2", 16'(d), 16'hC3);
        do_rd(4'b0110, d);
        check("R3 cmd0 untouched", 16'(d), 16'h00);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        do_reset(3'd2);
        do_wr(4'b0000, 8'h37);
        check("R4 addr_o", 16'(addr_o), 16'h037);
        do_rd(4'b0000, d);
        check("R4 readback", 16'(d), 16'h37);
    endtask

    task automatic t_ext_closed();
        logic [7:0] d;
        do_reset(3'd3);
        do_wr(4'b0000, 8'h01);
        do_wr(4'b1010, 8'h04);
        check("R5 cursor unchanged", 16'(cursor_big_o), 16'h0);
        check("R5 addr unchanged", 16'(addr_o), 16'h001);
        do_rd(4'b1010, d);
        check("R5 closed reads id", 16'(d), 16'hD0);
        do_wr(4'b0110, 8'h80);
        do_rd(4'b1010, d);
        check("R5 cmd3 not written", 16'(d), 16'h00);
        do_reset(3'd0);
        do_wr(4'b0110, 8'h80);
        do_wr(4'b0000, 8'h01);
        do_rd(4'b1010, d);
        check("R5 old variant reads id", 16'(d), 16'h80);
    endtask

    task automatic t_ids();
        logic [7:0] d;
        logic [7:0] ids [5] = '{8'h80, 8'h40, 8'hA0, 8'hD0, 8'h20};
        for (int v = 0; v < 5; v++) begin
            do_reset(3'(v));
            do_rd(4'b1010, d);
            check($sformatf("R6 id variant %0d", v), 16'(d), 16'(ids[v]));
        end
        do_wr(4'b0110, 8'h80);
        do_rd(4'b1010, d);
        check("R7 ext addr0 id", 16'(d), 16'h20);
    endtask

    task automatic t_cmd3();
        logic [7:0] d;
        do_reset(3'd2);
        do_wr(4'b0110, 8'h80);
        do_wr(4'b0000, 8'h01);
        do_wr(4'b1010, 8'h03);
        check("R10 small cursor", 16'(cursor_big_o), 16'h0);
        check("R10 small yoff", 16'(cursor_yoff_o), 16'd32);
        check("R11 addr kept", 16'(addr_o), 16'h001);
        do_rd(4'b1010, d);
        check("R7 cmd3 readback", 16'(d), 16'h03);
        do_wr(4'b1010, 8'h06);
        check("R10 big cursor", 16'(cursor_big_o), 16'h1);
        check("R10 big yoff", 16'(cursor_yoff_o), 16'd0);
        check("R11 addr hi loaded", 16'(addr_o), 16'h201);
        do_rd(4'b1010, d);
        check("R7 unmatched ext addr", 16'(d), 16'h00);
        do_wr(4'b0000, 8'h01);
        check("R4 hi cleared", 16'(addr_o), 16'h001);
        do_rd(4'b1010, d);
        check("R7 cmd3 again", 16'(d), 16'h06);
        do_wr(4'b1010, 8'h07);
        check("R11 addr hi 3", 16'(addr_o), 16'h301);
    endtask

    task automatic t_cmd4_sig();
        logic [7:0] d;
        do_reset(3'd4);
        do_wr(4'b0110, 8'h80);
        do_wr(4'b0000, 8'h02);
        do_wr(4'b1010, 8'h9C);
        do_rd(4'b1010, d);
        check("R8 cmd4 newest", 16'(d), 16'h9C);
        for (int a = 'h20; a <= 'h22; a++) begin
            do_wr(4'b0000, 8'(a));
            do_rd(4'b1010, d);
            check("R9 sig ones", 16'(d), 16'hFF);
        end
        do_wr(4'b0000, 8'h21);
        do_wr(4'b1010, 8'h11);
        do_wr(4'b0000, 8'h02);
        do_rd(4'b1010, d);
        check("R9 sig write ignored", 16'(d), 16'h9C);
        do_reset(3'd3);
        do_wr(4'b0110, 8'h80);
        do_wr(4'b0000, 8'h02);
        do_wr(4'b1010, 8'h9C);
        do_rd(4'b1010, d);
        check("R8 cmd4 absent", 16'(d), 16'h00);
        do_wr(4'b0000, 8'h21);
        do_rd(4'b1010, d);
        check("R9 sig absent", 16'(d), 16'h00);
    endtask

    task automatic t_old_cursor();
        for (int v = 0; v < 2; v++) begin
            do_reset(3'(v));
            do_wr(4'b0110, 8'h80);
            do_wr(4'b0000, 8'h01);
            do_wr(4'b1010, 8'h04);
            check("R12 old small", 16'(cursor_big_o), 16'h0);
            check("R12 old yoff", 16'(cursor_yoff_o), 16'd32);
            check("R12 old addr", 16'(addr_o), 16'h001);
        end
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        do_reset(3'd2);
        do_wr(4'b0110, 8'h42);
        do_wr(4'b0111, 8'hAA);
        do_wr(4'b1111, 8'h55);
        do_rd(4'b0111, d);
        check("R13 unmapped read", 16'(d), 16'h00);
        do_rd(4'b1111, d);
        check("R13 unmapped read F", 16'(d), 16'h00);
        do_rd(4'b0110, d);
        check("R13 cmd0 kept", 16'(d), 16'h42);
        do_rd(4'b1000, d);
        check("R13 cmd1 kept", 16'(d), 16'h00);
        check("R13 addr kept", 16'(addr_o), 16'h000);
    endtask

    initial begin
        t_reset();
        t_cmd0();
        t_cmd12();
        t_addr();
        t_ext_closed();
        t_ids();
        t_cmd3();
        t_cmd4_sig();
        t_old_cursor();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule